// File: doc/BRIEF.md
# Polarity-Steered Phase-Leg Gate Controller

This block drives the upper and lower switch gates of one inverter phase leg from a single ideal PWM command. When the load-current direction is known with confidence, only the switch that actually carries the current is gated. The opposite switch is held off. A switch in series with the opposite freewheeling diode cannot short the DC link, so this path needs no dead interval. When the current is near zero its sign cannot be trusted. In that case the block falls back to complementary gating, with a programmable blanking interval on every command edge.

Current is positive when it leaves the leg toward the load and negative when it flows back into the leg. A new gating mode is adopted only on a PWM command edge. Whenever the mode changes, both gates are blanked for one dead interval before the new pattern appears. The blanking length comes from a count input. That count is captured only during reset or while both gates are off, so a change in the middle of a pulse never alters an interval already in use.

Top module: `pdt_leg_gate`

## Requirements
- R1: Synchronous reset drives both gates low, sets the mode status to complementary (code 2'b00) and captures the dead-count input.
- R2: With near_zero low and cur_neg low, the leg is in positive mode (status code 2'b01). In this mode gate_hi equals pwm_cmd one clock later, gate_lo stays low, and no blanking occurs on command edges.
- R3: With near_zero low and cur_neg high, the leg is in negative mode (status code 2'b10). In this mode gate_lo equals the inverse of pwm_cmd one clock later and gate_hi stays low.
- R4: With near_zero high, the leg is in complementary mode (code 2'b00). Every command edge blanks both gates for N clocks, after which gate_hi equals pwm_cmd and gate_lo equals its inverse. A further edge during blanking restarts the interval.
- R5: The requested mode is adopted only in the clock where pwm_cmd differs from its value at the previous clock. The mode status changes with that same clock, and polarity or near-zero changes between edges have no effect on the gates.
- R6: A mode change at a command edge blanks both gates for N clocks before the new mode's gating appears.
- R7: Both gates are never high in the same clock, and a gate rises only after a clock in which the other gate was low.
- R8: N is the captured dead count, with a captured zero treated as one. The count is captured at a clock edge only while reset is high or both gates are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 1 | Ideal PWM command (1 = upper switch wanted on) |
| cur_neg | input | 1 | Load-current sign, 1 = flowing into the leg |
| near_zero | input | 1 | Current magnitude too small to trust its sign |
| dt_cycles | input | DTW | Dead interval length in clocks |
| gate_hi | output | 1 | Upper switch gate |
| gate_lo | output | 1 | Lower switch gate |
| mode | output | 2 | Active mode: 00 complementary, 01 positive, 10 negative |

## Verification
Several properties are checked by assertions on every cycle:
- the gates are never both high,
- the idle switch stays off in each single-switch mode,
- a gate turns on only after the other gate was low,
- a mode change coincides with both gates off,
- the mode moves only in a clock flagged as a command edge.

The exact blanking lengths can only be shown by the bench's scenarios. So can the fact that a stale dead count is kept while a gate is on, and the zero-to-one substitution. The same holds for the claim that polarity changes between edges leave the gates untouched.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic [1:0] {
    MODE_DT  = 2'b00,
    MODE_POS = 2'b01,
    MODE_NEG = 2'b10
  } leg_mode_e;

  // returns {hi, lo} for a mode and command level
  function automatic logic [1:0] gate_map(leg_mode_e m, logic cmd);
    case (m)
      MODE_POS: gate_map = {cmd, 1'b0};
      MODE_NEG: gate_map = {1'b0, ~cmd};
      default:  gate_map = {cmd, ~cmd};
    endcase
  endfunction
endpackage

// File: rtl/pdt_edge_tracker.sv
module pdt_edge_tracker (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  output logic pwm_edge
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_in;
  end

  assign pwm_edge = !rst && (pwm_in != pwm_q);
endmodule

// File: rtl/pdt_dead_counter.sv
module pdt_dead_counter #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [DTW-1:0] dt_in,
  input  logic           load_ok,
  input  logic           start,
  output logic           hold
);
  localparam logic [DTW-1:0] ONE = DTW'(1);

  logic [DTW-1:0] dt_len;
  logic [DTW-1:0] cnt;
  logic [DTW-1:0] n_eff;

  always_ff @(posedge clk) begin
    if (rst || load_ok) dt_len <= dt_in;
  end

  assign n_eff = (dt_len == '0) ? ONE : dt_len;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= n_eff;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign hold = start || (cnt > ONE);

  a_r8_start_loads: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt != '0));
endmodule

// File: rtl/pdt_leg_gate.sv
module pdt_leg_gate #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwm_cmd,
  input  logic           cur_neg,
  input  logic           near_zero,
  input  logic [DTW-1:0] dt_cycles,
  output logic           gate_hi,
  output logic           gate_lo,
  output logic [1:0]     mode
);
  import pdt_pkg::*;

  leg_mode_e mode_q, mode_req, mode_nxt;
  logic      pwm_edge, start, hold, both_off;
  logic [1:0] gates_nxt;

  pdt_edge_tracker u_edge (
    .clk(clk), .rst(rst), .pwm_in(pwm_cmd), .pwm_edge(pwm_edge)
  );

  assign both_off = !gate_hi && !gate_lo;

  pdt_dead_counter #(.DTW(DTW)) u_dead (
    .clk(clk), .rst(rst), .dt_in(dt_cycles), .load_ok(both_off),
    .start(start), .hold(hold)
  );

  always_comb begin
    if (near_zero)    mode_req = MODE_DT;
    else if (cur_neg) mode_req = MODE_NEG;
    else              mode_req = MODE_POS;
  end

  assign mode_nxt  = pwm_edge ? mode_req : mode_q;
  assign start     = pwm_edge && ((mode_req != mode_q) || (mode_req == MODE_DT));
  assign gates_nxt = hold ? 2'b00 : gate_map(mode_nxt, pwm_cmd);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_DT;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      gate_hi <= gates_nxt[1];
      gate_lo <= gates_nxt[0];
    end
  end

  assign mode = mode_q;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!gate_hi && !gate_lo && mode_q == MODE_DT));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));
  a_r7_hi_after_lo_off: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> $past(!gate_lo));
  a_r7_lo_after_hi_off: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_lo) |-> $past(!gate_hi));
  a_r2_pos_lo_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_POS) |-> !gate_lo);
  a_r3_neg_hi_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NEG) |-> !gate_hi);
  a_r5_mode_on_edge: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(pwm_edge));
  a_r6_change_blanks: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> (!gate_hi && !gate_lo));
endmodule

// File: tb/sim_pdt_leg_gate.sv
module sim_pdt_leg_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_cmd = 1'b0, cur_neg = 1'b0, near_zero = 1'b1;
  logic [7:0] dt_cycles = 8'd3;
  logic gate_hi, gate_lo;
  logic [1:0] mode;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pdt_leg_gate #(.DTW(8)) u0 (
    .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .cur_neg(cur_neg),
    .near_zero(near_zero), .dt_cycles(dt_cycles),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .mode(mode)
  );

  task automatic chk(string req, logic [1:0] em, logic eh, logic el);
    n_run++;
    if ({mode, gate_hi, gate_lo} !== {em, eh, el}) begin
      n_fail++;
      $display("FAIL %s: mode/hi/lo actual %b/%b/%b expected %b/%b/%b",
               req, mode, gate_hi, gate_lo, em, eh, el);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // blanking for n clocks, then gates (eh,el)
  task automatic expect_dead(string req, logic [1:0] em, int n, logic eh, logic el);
    for (int i = 0; i < n; i++) begin step(1); chk(req, em, 1'b0, 1'b0); end
    step(1); chk(req, em, eh, el);
  endtask

  task automatic t_reset;
    step(2); chk("R1", 2'b00, 1'b0, 1'b0);
    rst = 1'b0;
    step(1); chk("R4", 2'b00, 1'b0, 1'b1);
  endtask

  task automatic t_complementary;
    pwm_cmd = 1'b1; expect_dead("R4", 2'b00, 3, 1'b1, 1'b0);
    pwm_cmd = 1'b0; step(1); chk("R4", 2'b00, 1'b0, 1'b0);
    pwm_cmd = 1'b1; expect_dead("R4 restart", 2'b00, 3, 1'b1, 1'b0);
  endtask

  task automatic t_positive;
    near_zero = 1'b0; cur_neg = 1'b0; pwm_cmd = 1'b0;
    expect_dead("R6", 2'b01, 3, 1'b0, 1'b0);
    pwm_cmd = 1'b1; step(1); chk("R2", 2'b01, 1'b1, 1'b0);
    pwm_cmd = 1'b0; step(1); chk("R2", 2'b01, 1'b0, 1'b0);
  endtask

  task automatic t_negative;
    cur_neg = 1'b1; pwm_cmd = 1'b1;
    expect_dead("R6", 2'b10, 3, 1'b0, 1'b0);
    pwm_cmd = 1'b0; step(1); chk("R3", 2'b10, 1'b0, 1'b1);
  endtask

  task automatic t_flip;
    cur_neg = 1'b0; pwm_cmd = 1'b1;
    expect_dead("R6", 2'b01, 3, 1'b1, 1'b0);
  endtask

  task automatic t_no_edge;
    cur_neg = 1'b1; step(5); chk("R5", 2'b01, 1'b1, 1'b0);
    near_zero = 1'b1; step(3); chk("R5", 2'b01, 1'b1, 1'b0);
    near_zero = 1'b0; cur_neg = 1'b0;
  endtask

  task automatic t_dead_count;
    dt_cycles = 8'd5; step(1);
    near_zero = 1'b1; pwm_cmd = 1'b0;
    expect_dead("R8 stale", 2'b00, 3, 1'b0, 1'b1);
    pwm_cmd = 1'b1; expect_dead("R8 fresh", 2'b00, 5, 1'b1, 1'b0);
    dt_cycles = 8'd0; step(1);
    pwm_cmd = 1'b0; expect_dead("R8 held", 2'b00, 5, 1'b0, 1'b1);
    pwm_cmd = 1'b1; expect_dead("R8 zero", 2'b00, 1, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_complementary();
    t_positive();
    t_negative();
    t_flip();
    t_no_edge();
    t_dead_count();
    step(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule